// File: doc/BRIEF.md
# Vector-Priority Interrupt Controller

This block is the interrupt unit of a small single-issue CPU. It gathers a set of interrupt sources, applies a per-source enable and a global enable gate, and at each instruction boundary hands the core the vector of the highest-priority request that can be served. Each source is one of two kinds, chosen per bit by a parameter mask. An edge-type source sets a pending flag that holds until it is served or cleared. A level-type source requests only while its input stays high.

Priority follows the source index. Source 0 is vector 1 and has the highest priority. Vector 0 belongs to reset, which sits above every interrupt. The global gate is a three-state machine:
- `ST_MASKED`: gate closed.
- `ST_OPEN`: gate open, and interrupts can be taken.
- `ST_HOLD`: gate open, but the next interrupt is held off until one instruction has retired.

The state moves as follows:
- **take**: OPEN to MASKED, when a request is served.
- **disable**: any state to MASKED, on a disable command.
- **enable**: MASKED to OPEN, on an enable command.
- **return**: MASKED or OPEN to HOLD, on a return strobe.
- **retire**: HOLD to OPEN, on the first instruction boundary after a return.

A boot-select input moves all vectors from a base of zero to a parameter base. Each vector slot is two program words long.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `gie_o`, `take_o`, `pend_o`, `vec_num_o` and `vec_addr_o` are all zero, and the gate is in ST_MASKED.
- R2: When several requests can be served at once, the lowest source index wins. Source index i is reported as `vec_num_o` = i+1.
- R3: A request is served only at a cycle with `boundary_i` high, with the gate in ST_OPEN and with the source's own `src_en_i` bit set. `take_o` pulses high in the following cycle, together with the new vector outputs.
- R4: Serving a request closes the gate, so `gie_o` is low in the cycle that `take_o` is high. Serving an edge-type source clears its pending flag.
- R5: A cycle with `clr_wr_i` high clears each edge-type pending flag whose `clr_mask_i` bit is 1. Flags whose mask bit is 0 are untouched. An event on the same source in the same cycle wins over the clear.
- R6: An edge-type event that arrives while its source is masked, locally or globally, stays pending. Pending flags are served one after another in priority order.
- R7: A level-type source (bits 6 and 7 by default) never latches, and its `pend_o` bit reads 0. If its input falls before the source is enabled, no interrupt follows.
- R8: After `reti_i`, `gie_o` is high, but the first `boundary_i` takes nothing. A request can be served from the second boundary on. No request is served in the cycle of `reti_i` itself.
- R9: `cli_i` closes the gate in the next cycle and blocks a take in its own cycle, even when a boundary and a request arrive in that same cycle. `cli_i` wins over `sei_i` and `reti_i`.
- R10: `vec_addr_o` equals 2*`vec_num_o`, plus `BOOT_BASE` when `boot_sel_i` was high at the take. The default `BOOT_BASE` is 0xF000.
- R11: If the gate is opened again inside a handler, any enabled request, of any priority, is served at the next boundary.
- R12: `sei_i` while the gate is closed opens it in the next cycle (state ST_OPEN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | N_SRC | Event pulse (edge-type) or condition level (level-type) per source |
| src_en_i | input | N_SRC | Per-source enable |
| boundary_i | input | 1 | An instruction retires this cycle |
| reti_i | input | 1 | A return-from-interrupt retires this cycle |
| sei_i | input | 1 | Global enable command |
| cli_i | input | 1 | Global disable command |
| clr_wr_i | input | 1 | Write-one-to-clear strobe for pending flags |
| clr_mask_i | input | N_SRC | Flags to clear when `clr_wr_i` is high |
| boot_sel_i | input | 1 | Select the boot vector base |
| take_o | output | 1 | One-cycle pulse: a vector was taken |
| vec_num_o | output | VN_W | Number of the last vector taken |
| vec_addr_o | output | VEC_W | Program address of the last vector taken |
| gie_o | output | 1 | Global enable state |
| pend_o | output | N_SRC | Edge-type pending flags |

## Verification
The hardest situation to reach is the one-instruction hold after a return. A flag must already be pending and enabled, a return must arrive, and then two boundaries must follow without an intervening disable. Directed sequences build exactly this, and also a disable that lands on the same cycle as a boundary and a pending request. A long run of seeded random strobes, events and clears then mixes returns, enables and disables densely. Each random cycle is compared against a bench model of the gate and the flags.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_MASKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_HOLD   = 2'd2
    } gate_st_t;
endpackage

// File: rtl/irq_flag_bank.sv
// Pending-flag storage for edge-type sources; level-type bits stay zero.
module irq_flag_bank #(
    parameter int          N_SRC      = 8,
    parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic             clr_wr,
    input  logic [N_SRC-1:0] clr_mask,
    input  logic [N_SRC-1:0] serve_oh,
    output logic [N_SRC-1:0] flag_q
);
    localparam logic [N_SRC-1:0] EDGE_MASK = ~LEVEL_MASK;

    logic [N_SRC-1:0] drop;
    logic [N_SRC-1:0] flag_d;

    always_comb begin
        drop   = serve_oh | (clr_wr ? clr_mask : '0);
        // a fresh event wins over a clear or a serve in the same cycle
        flag_d = ((evt | (flag_q & ~drop)) & EDGE_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority pick: lowest index wins.
module irq_prio_pick #(
    parameter int N_SRC = 8,
    localparam int IW   = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] req,
    output logic             hit,
    output logic [IW-1:0]    idx,
    output logic [N_SRC-1:0] onehot
);
    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        hit    = |req;
        onehot = hit ? (N_SRC'(1) << idx) : '0;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int               N_SRC      = 8,
    parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hC0,
    parameter int               VEC_W      = 16,
    parameter logic [VEC_W-1:0] BOOT_BASE  = 16'hF000,
    localparam int              IW         = $clog2(N_SRC),
    localparam int              VN_W       = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt_i,
    input  logic [N_SRC-1:0] src_en_i,
    input  logic             boundary_i,
    input  logic             reti_i,
    input  logic             sei_i,
    input  logic             cli_i,
    input  logic             clr_wr_i,
    input  logic [N_SRC-1:0] clr_mask_i,
    input  logic             boot_sel_i,
    output logic             take_o,
    output logic [VN_W-1:0]  vec_num_o,
    output logic [VEC_W-1:0] vec_addr_o,
    output logic             gie_o,
    output logic [N_SRC-1:0] pend_o
);
    gate_st_t st_q, st_d;

    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] req;
    logic [N_SRC-1:0] win_oh;
    logic [N_SRC-1:0] serve_oh;
    logic [IW-1:0]    win_idx;
    logic             win_hit;
    logic             can_take;
    logic [VN_W-1:0]  vnum_d;
    logic [VEC_W-1:0] vaddr_d;

    irq_flag_bank #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src_evt_i),
        .clr_wr   (clr_wr_i),
        .clr_mask (clr_mask_i),
        .serve_oh (serve_oh),
        .flag_q   (flag_q)
    );

    // edge-type sources request from their flag, level-type from the live input
    assign req = src_en_i & (flag_q | (src_evt_i & LEVEL_MASK));

    irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
        .req    (req),
        .hit    (win_hit),
        .idx    (win_idx),
        .onehot (win_oh)
    );

    assign can_take = (st_q == ST_OPEN) && boundary_i && !cli_i && !reti_i && win_hit;
    assign serve_oh = can_take ? win_oh : '0;

    // next-state logic of the global gate
    always_comb begin
        st_d = st_q;
        if (cli_i) begin
            st_d = ST_MASKED;                       // disable
        end else if (can_take) begin
            st_d = ST_MASKED;                       // take
        end else begin
            unique case (st_q)
                ST_MASKED: begin
                    if (reti_i)     st_d = ST_HOLD; // return
                    else if (sei_i) st_d = ST_OPEN; // enable
                end
                ST_OPEN: begin
                    if (reti_i)     st_d = ST_HOLD; // return
                end
                ST_HOLD: begin
                    if (boundary_i) st_d = ST_OPEN; // retire
                end
                default:            st_d = ST_MASKED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_MASKED;
        else        st_q <= st_d;
    end

    always_comb begin
        vnum_d  = VN_W'(win_idx) + VN_W'(1);
        vaddr_d = (boot_sel_i ? BOOT_BASE : '0) + (VEC_W'(vnum_d) << 1);
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            vec_num_o  <= '0;
            vec_addr_o <= '0;
        end else begin
            take_o <= can_take;
            if (can_take) begin
                vec_num_o  <= vnum_d;
                vec_addr_o <= vaddr_d;
            end
        end
    end

    assign gie_o  = (st_q != ST_MASKED);
    assign pend_o = flag_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_evt_i,
    input logic             boundary_i,
    input logic             reti_i,
    input logic             sei_i,
    input logic             cli_i,
    input logic             clr_wr_i,
    input logic [N_SRC-1:0] clr_mask_i,
    input logic             take_o,
    input logic             gie_o,
    input logic [N_SRC-1:0] pend_o
);
    a_r4_take_closes_gate: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !gie_o);

    a_r3_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(boundary_i) && $past(gie_o)));

    a_r9_cli_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cli_i |=> (!take_o && !gie_o));

    a_r8_no_take_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !take_o);

    a_r12_sei_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (sei_i && !cli_i && !gie_o) |=> gie_o);

    for (genvar i = 0; i < N_SRC; i++) begin : g_clr
        a_r5_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i && clr_mask_i[i] && !src_evt_i[i]) |=> !pend_o[i]);
    end
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt_i  (src_evt_i),
    .boundary_i (boundary_i),
    .reti_i     (reti_i),
    .sei_i      (sei_i),
    .cli_i      (cli_i),
    .clr_wr_i   (clr_wr_i),
    .clr_mask_i (clr_mask_i),
    .take_o     (take_o),
    .gie_o      (gie_o),
    .pend_o     (pend_o)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    localparam int          N  = 8;
    localparam logic [7:0]  LM = 8'hC0;
    localparam logic [15:0] BB = 16'hF000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0, en = '0, clr_mask = '0;
    logic        boundary = 0, reti = 0, sei = 0, cli = 0, clr_wr = 0, bsel = 0;
    logic        take;
    logic [3:0]  vnum;
    logic [15:0] vaddr;
    logic        gie;
    logic [7:0]  pend;

    always #2 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt_i(evt), .src_en_i(en),
        .boundary_i(boundary), .reti_i(reti), .sei_i(sei), .cli_i(cli),
        .clr_wr_i(clr_wr), .clr_mask_i(clr_mask), .boot_sel_i(bsel),
        .take_o(take), .vec_num_o(vnum), .vec_addr_o(vaddr),
        .gie_o(gie), .pend_o(pend)
    );

    int nchk = 0, nbad = 0;
    bit done = 0;

    // bench model: 0 masked, 1 open, 2 hold
    int          m_st = 0;
    logic [7:0]  m_pend = '0;
    logic        m_take = 0;
    logic [3:0]  m_vnum = '0;
    logic [15:0] m_vaddr = '0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lowest(logic [7:0] r);
        for (int i = 7; i >= 0; i--) if (r[i]) lowest = i;
    endfunction

    task automatic model_next();
        logic [7:0] r;
        logic       can;
        int         w;
        r   = en & (m_pend | (evt & LM));
        can = (m_st == 1) && boundary && !cli && !reti && (r != 0);
        w   = lowest(r);
        if (r == 0) w = 0;
        m_pend = ((evt & ~LM) | (m_pend & ~(clr_wr ? clr_mask : 8'h00)
                 & ~(can ? (8'h01 << w) : 8'h00))) & ~LM;
        m_take = can;
        if (can) begin
            m_vnum  = 4'(w + 1);
            m_vaddr = (bsel ? BB : 16'h0) + 16'((w + 1) * 2);
        end
        if (cli || can) m_st = 0;
        else if (m_st == 0) m_st = reti ? 2 : (sei ? 1 : 0);
        else if (m_st == 1) m_st = reti ? 2 : 1;
        else m_st = boundary ? 1 : 2;
    endtask

    // apply current inputs for one cycle, compare with model, release strobes
    task automatic step(string tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        check({tag, " take"}, 32'(take), 32'(m_take));
        check({tag, " gie"},  32'(gie),  32'(m_st != 0));
        check({tag, " pend"}, 32'(pend), 32'(m_pend));
        check({tag, " vnum"}, 32'(vnum), 32'(m_vnum));
        check({tag, " vaddr"}, 32'(vaddr), 32'(m_vaddr));
        boundary = 0; reti = 0; sei = 0; cli = 0; clr_wr = 0; clr_mask = '0;
        evt = evt & LM;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            nbad++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 gie", 32'(gie), 0);
        check("R1 take", 32'(take), 0);
        check("R1 pend", 32'(pend), 0);
        check("R1 vnum", 32'(vnum), 0);
        check("R1 vaddr", 32'(vaddr), 0);
        rst_n = 1;

        // R6: masked events stay pending, then served in order
        en = 8'h00; evt = 8'h0A; step("R6");
        check("R6 pending kept", 32'(pend), 32'h0A);
        sei = 1; step("R12");
        check("R12 gie open", 32'(gie), 1);
        boundary = 1; step("R3");
        check("R3 no take when source disabled", 32'(take), 0);
        en = 8'hFF; boundary = 1; step("R2");
        check("R2 lowest wins", 32'(vnum), 2);
        check("R4 gie closed", 32'(gie), 0);
        check("R4 flag cleared", 32'(pend), 32'h08);
        check("R10 base zero", 32'(vaddr), 4);
        reti = 1; step("R8");
        check("R8 gie after return", 32'(gie), 1);
        boundary = 1; step("R8");
        check("R8 first boundary holds", 32'(take), 0);
        boundary = 1; step("R8");
        check("R8 second boundary takes", 32'(take), 1);
        check("R6 next in order", 32'(vnum), 4);

        // R5 write-one-to-clear
        evt = 8'h04; step("R5");
        clr_wr = 1; clr_mask = 8'h04; step("R5");
        check("R5 cleared", 32'(pend), 0);
        evt = 8'h10; clr_wr = 1; clr_mask = 8'h10; step("R5");
        check("R5 event wins", 32'(pend), 32'h10);
        clr_wr = 1; clr_mask = 8'h01; step("R5");
        check("R5 zero bit no effect", 32'(pend), 32'h10);

        // R9 disable in same cycle as boundary and request
        sei = 1; step("R9");
        boundary = 1; cli = 1; step("R9");
        check("R9 blocked take", 32'(take), 0);
        check("R9 gie closed", 32'(gie), 0);

        // R10 boot base
        bsel = 1; sei = 1; step("R10");
        boundary = 1; step("R10");
        check("R10 boot addr", 32'(vaddr), 32'hF00A);

        // R11 nesting: reopen inside handler, level source 7 taken
        sei = 1; step("R11");
        evt = 8'h80; boundary = 1; step("R11");
        check("R11 nested take", 32'(take), 1);
        check("R11 vnum", 32'(vnum), 8);
        evt = 8'h00; step("R11");

        // R7 level source gone before enable
        en = 8'hBF; evt = 8'h40; step("R7");
        check("R7 no latch", 32'(pend[6]), 0);
        evt = 8'h00; step("R7");
        en = 8'hFF; sei = 1; step("R7");
        boundary = 1; step("R7");
        check("R7 no interrupt", 32'(take), 0);

        // random mix, checked against model every cycle (R2 R3 R4 R5 R6 R8 R9)
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(49) == 0) en = 8'($urandom);
            for (int b = 0; b < 6; b++) evt[b] = ($urandom_range(9) == 0);
            for (int b = 6; b < 8; b++) if ($urandom_range(15) == 0) evt[b] = ~evt[b];
            boundary = $urandom_range(1);
            reti = ($urandom_range(11) == 0);
            sei  = ($urandom_range(7) == 0);
            cli  = ($urandom_range(13) == 0);
            clr_wr = ($urandom_range(7) == 0);
            clr_mask = 8'($urandom);
            if ($urandom_range(29) == 0) bsel = ~bsel;
            step("R2/R3/R4/R5/R6/R8/R9 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule